// File: doc/BRIEF.md
# Banked GPIO Pin Control Registers

This block is a register-mapped general-purpose I/O controller for `NUM_PINS` pins. `NUM_PINS` is a multiple of 32, typically 64, 96 or 192. Software reaches it over a plain 32-bit register bus that has separate write and read strobes. For each pin the block provides:

- a readback of the pad level,
- a direction bit,
- an output data latch that changes only through a write-one-to-set strobe word or a write-one-to-clear strobe word, so no read-modify-write is needed,
- a 2-bit function selector. A selector of zero leaves the pin under GPIO control. Any other value hands the pad to another function, which drives the pad through its own output and enable vectors.

Registers are grouped by feature. Each group of one-bit-per-pin features takes `NREG = NUM_PINS/32` consecutive words. The word index is `feature*NREG + pin/32`. The group codes 4 to 6 are kept in the address map for edge-detection features that this block does not provide. Read accesses pass through a two-state bus machine:

- `BUS_IDLE` moves to `BUS_RESP` on a read strobe.
- `BUS_RESP` stays in `BUS_RESP` while reads keep arriving back to back.
- `BUS_RESP` returns to `BUS_IDLE` when no read is present.

Top module: `gpio_bank_regs`

## Requirements
- R1: While reset is held, every pin is an input (`pad_oe` all zero), the output latch and all function selectors are zero (`pad_out` all zero), and `reg_rvalid` is low.
- R2: The byte address is 4 times the word index. The word index of a one-bit-per-pin feature is `code*NREG + pin/32`, and the pin occupies bit `pin%32`. The feature codes are: 0 level, 1 direction, 2 set, 3 clear, 4 to 6 reserved, 7 function select.
- R3: Code 0 reads the current `pad_in` bits of the addressed bank. Writes to code 0 change nothing.
- R4: A direction bit of 1 makes the pin an output and 0 makes it an input. The written word reads back unchanged.
- R5: Writing to code 2 sets the latch bits where the data word has ones and leaves the other bits alone. Reading code 2 returns the latch.
- R6: Writing to code 3 clears the latch bits where the data word has ones and leaves the other bits alone. Reading code 3 returns the latch.
- R7: The function selector of a pin is 2 bits wide. It sits in word `7*NREG + pin/16`, bits `2*(pin%16)+1 : 2*(pin%16)`. The written word reads back unchanged.
- R8: When a pin's selector is 0, `pad_oe` equals its direction bit and `pad_out` equals its latch bit. When the selector is nonzero, the pin takes `func_oe` and `func_out` instead. A register write shows on the pads after the same clock edge that takes it.
- R9: A read strobe makes `reg_rvalid` high in the following cycle only. `reg_rdata` then holds the word as it stood at the strobe edge, before any write in that same cycle. `reg_rdata` keeps that value until the next read.
- R10: Codes 4 to 6, and word indices of `9*NREG` and above, read as zero. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| reg_rvalid | output | 1 | Read data valid, one cycle after the strobe |
| pad_in | input | NUM_PINS | Pad levels, assumed already synchronous |
| func_out | input | NUM_PINS | Output values from the other pin functions |
| func_oe | input | NUM_PINS | Output enables from the other pin functions |
| pad_out | output | NUM_PINS | Pad output value |
| pad_oe | output | NUM_PINS | Pad output enable |

## Verification
Timing of each result:

- A write lands at the clock edge that samples it, and its effect on `pad_out` and `pad_oe` is due straight after that edge.
- `func_out` and `func_oe` pass combinationally in the same cycle.
- Read data and `reg_rvalid` are due one edge after the read strobe.

The bench keeps a behavioural model that is updated at each rising edge from the inputs applied before that edge. At the following falling edge it compares every output with the model, so each result is checked in exactly the cycle it is due. The model evaluates a read before it applies a write in the same cycle, which matches R9.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Feature group codes; the numeric order fixes the address map.
    typedef enum logic [2:0] {
        FT_LEVEL = 3'd0,
        FT_DIR   = 3'd1,
        FT_SET   = 3'd2,
        FT_CLR   = 3'd3,
        FT_RISE  = 3'd4,
        FT_FALL  = 3'd5,
        FT_EDGE  = 3'd6,
        FT_ALT   = 3'd7
    } feat_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_st_e;

    typedef struct packed {
        logic       valid;
        feat_e      feat;
        logic [7:0] idx;
    } gpio_dec_t;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned SEL_W    = 2;
    localparam int unsigned ALT_BASE = 7;   // group index of function selectors
    localparam int unsigned ALT_SPAN = 2;   // selector groups take 2*NREG words

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NREG   = 2,
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output gpio_dec_t         dec
);
    localparam int unsigned ALT_LO = ALT_BASE * NREG;
    localparam int unsigned ALT_HI = (ALT_BASE + ALT_SPAN) * NREG;

    logic [31:0] word;

    always_comb begin
        word      = 32'(addr >> 2);
        dec.valid = 1'b0;
        dec.feat  = FT_RISE;
        dec.idx   = '0;
        if (word < ALT_LO) begin
            dec.valid = 1'b1;
            dec.feat  = feat_e'(3'(word / NREG));
            dec.idx   = 8'(word % NREG);
        end else if (word < ALT_HI) begin
            dec.valid = 1'b1;
            dec.feat  = FT_ALT;
            dec.idx   = 8'(word - ALT_LO);
        end
    end
endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank
    import gpio_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_dir,
    input  logic              wr_set,
    input  logic              wr_clr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] dir_q,
    output logic [WORD_W-1:0] lat_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (wr_dir) begin
            dir_q <= wdata;
        end
    end

    // Strobe-only update of the output latch.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (wr_set) begin
            lat_q <= lat_q | wdata;
        end else if (wr_clr) begin
            lat_q <= lat_q & ~wdata;
        end
    end
endmodule

// File: rtl/gpio_sel_word.sv
module gpio_sel_word
    import gpio_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] sel_q
);
    localparam int unsigned FIELDS = WORD_W / SEL_W;

    for (genvar f = 0; f < FIELDS; f++) begin : g_field
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sel_q[f*SEL_W +: SEL_W] <= '0;
            end else if (wr) begin
                sel_q[f*SEL_W +: SEL_W] <= wdata[f*SEL_W +: SEL_W];
            end
        end
    end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_PINS = 64
) (
    input  logic [NUM_PINS-1:0]       dir_vec,
    input  logic [NUM_PINS-1:0]       lat_vec,
    input  logic [SEL_W*NUM_PINS-1:0] sel_vec,
    input  logic [NUM_PINS-1:0]       func_out,
    input  logic [NUM_PINS-1:0]       func_oe,
    output logic [NUM_PINS-1:0]       pad_out,
    output logic [NUM_PINS-1:0]       pad_oe
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic gpio_owned;
        assign gpio_owned = (sel_vec[p*SEL_W +: SEL_W] == '0);
        assign pad_oe[p]  = gpio_owned ? dir_vec[p] : func_oe[p];
        assign pad_out[p] = gpio_owned ? lat_vec[p] : func_out[p];
    end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_PINS = 64,
    parameter int unsigned ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                reg_rvalid,
    input  logic [NUM_PINS-1:0] pad_in,
    input  logic [NUM_PINS-1:0] func_out,
    input  logic [NUM_PINS-1:0] func_oe,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe
);
    localparam int unsigned NREG = NUM_PINS / WORD_W;
    localparam int unsigned NSEL = NREG * ALT_SPAN;

    gpio_dec_t                 dec;
    logic                      wr_hit;
    logic [NUM_PINS-1:0]       dir_vec;
    logic [NUM_PINS-1:0]       lat_vec;
    logic [SEL_W*NUM_PINS-1:0] sel_vec;
    logic [31:0]               rd_mux;
    bus_st_e                   state, state_nxt;

    gpio_addr_decode #(.NREG(NREG), .ADDR_W(ADDR_W)) u_dec (
        .addr (reg_addr),
        .dec  (dec)
    );

    assign wr_hit = reg_wr && dec.valid;

    for (genvar b = 0; b < NREG; b++) begin : g_bank
        logic sel_b;
        assign sel_b = wr_hit && (int'(dec.idx) == b);
        gpio_pin_bank u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_dir (sel_b && dec.feat == FT_DIR),
            .wr_set (sel_b && dec.feat == FT_SET),
            .wr_clr (sel_b && dec.feat == FT_CLR),
            .wdata  (reg_wdata),
            .dir_q  (dir_vec[b*WORD_W +: WORD_W]),
            .lat_q  (lat_vec[b*WORD_W +: WORD_W])
        );
    end

    for (genvar s = 0; s < NSEL; s++) begin : g_sel
        gpio_sel_word u_sel (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (wr_hit && dec.feat == FT_ALT && int'(dec.idx) == s),
            .wdata (reg_wdata),
            .sel_q (sel_vec[s*WORD_W +: WORD_W])
        );
    end

    gpio_pad_mux #(.NUM_PINS(NUM_PINS)) u_mux (
        .dir_vec  (dir_vec),
        .lat_vec  (lat_vec),
        .sel_vec  (sel_vec),
        .func_out (func_out),
        .func_oe  (func_oe),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );

    // Read data selection from the decoded group.
    always_comb begin
        rd_mux = '0;
        if (dec.valid) begin
            unique case (dec.feat)
                FT_LEVEL:        rd_mux = pad_in [int'(dec.idx)*WORD_W +: WORD_W];
                FT_DIR:          rd_mux = dir_vec[int'(dec.idx)*WORD_W +: WORD_W];
                FT_SET, FT_CLR:  rd_mux = lat_vec[int'(dec.idx)*WORD_W +: WORD_W];
                FT_ALT:          rd_mux = sel_vec[int'(dec.idx)*WORD_W +: WORD_W];
                FT_RISE, FT_FALL, FT_EDGE: rd_mux = '0;
            endcase
        end
    end

    // Bus state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= BUS_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions: IDLE->RESP on read, RESP->RESP on back-to-back read,
    // RESP->IDLE otherwise.
    always_comb begin
        unique case (state)
            BUS_IDLE: state_nxt = reg_rd ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_nxt = reg_rd ? BUS_RESP : BUS_IDLE;
        endcase
    end

    // Outputs of the bus machine.
    always_comb begin
        reg_rvalid = (state == BUS_RESP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int unsigned NUM_PINS = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic                reg_rd,
    input logic [31:0]         reg_rdata,
    input logic                reg_rvalid,
    input logic [NUM_PINS-1:0] func_out,
    input logic [NUM_PINS-1:0] func_oe,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe
);
    logic wr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= 1'b1;
        end else begin
            wr_q <= reg_wr;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        (!rst_n && $past(!rst_n)) |-> (pad_oe == '0 && pad_out == '0 && !reg_rvalid));

    p_read_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);

    p_no_stray_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> !reg_rvalid);

    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

    p_pads_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_q && $stable(func_out) && $stable(func_oe))
            |-> ($stable(pad_out) && $stable(pad_oe)));
endmodule

bind gpio_bank_regs gpio_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_rdata  (reg_rdata),
    .reg_rvalid (reg_rvalid),
    .func_out   (func_out),
    .func_oe    (func_oe),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe)
);

// File: tb/tb_gpio_bank_regs.sv
`timescale 1ns/1ps
module tb_gpio_bank_regs;
    localparam int NP   = 64;
    localparam int NREG = NP / 32;
    localparam int AW   = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          reg_rvalid;
    logic [NP-1:0] pad_in = '0, func_out = '0, func_oe = '0;
    logic [NP-1:0] pad_out, pad_oe;

    int vectors = 0, miscompares = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    gpio_bank_regs #(.NUM_PINS(NP), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .pad_in(pad_in), .func_out(func_out),
        .func_oe(func_oe), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // Behavioural reference state.
    logic [NP-1:0]   m_dir = '0, m_lat = '0;
    logic [2*NP-1:0] m_sel = '0;
    logic [31:0]     m_rdata = '0;
    bit              m_rvalid = 0;
    string           m_tag = "R9";

    function automatic logic [31:0] ref_read(input int a, output string tag);
        int w = a / 4;
        if (w < 7*NREG) begin
            int t = w / NREG, b = w % NREG;
            logic [31:0] d;
            case (t)
                0: begin d = pad_in[b*32 +: 32]; tag = "R3"; end
                1: begin d = m_dir[b*32 +: 32];  tag = "R4"; end
                2: begin d = m_lat[b*32 +: 32];  tag = "R5"; end
                3: begin d = m_lat[b*32 +: 32];  tag = "R6"; end
                default: begin d = 32'h0;        tag = "R10"; end
            endcase
            if (b != 0) tag = {"R2 ", tag};
            return d;
        end else if (w < 9*NREG) begin
            tag = (w != 7*NREG) ? "R2 R7" : "R7";
            return m_sel[(w-7*NREG)*32 +: 32];
        end
        tag = "R10";
        return 32'h0;
    endfunction

    task automatic ref_write(input int a, input logic [31:0] d);
        int w = a / 4;
        if (w < 7*NREG) begin
            int t = w / NREG, b = w % NREG;
            case (t)
                1: m_dir[b*32 +: 32] = d;
                2: m_lat[b*32 +: 32] = m_lat[b*32 +: 32] | d;
                3: m_lat[b*32 +: 32] = m_lat[b*32 +: 32] & ~d;
                default: ;
            endcase
        end else if (w < 9*NREG) begin
            m_sel[(w-7*NREG)*32 +: 32] = d;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir = '0; m_lat = '0; m_sel = '0;
            m_rvalid = 0; m_rdata = '0; m_tag = "R9";
        end else begin
            if (reg_rd) begin
                string tg;
                m_rdata = ref_read(int'(reg_addr), tg);
                m_tag = tg;
                m_rvalid = 1;
            end else begin
                m_rvalid = 0;
            end
            if (reg_wr) ref_write(int'(reg_addr), reg_wdata);
        end
    end

    task automatic check(input bit ok, input string tag,
                         input logic [NP-1:0] act, input logic [NP-1:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc();
        logic [NP-1:0] e_out, e_oe;
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            bit own = (m_sel[2*p +: 2] == 2'b00);
            e_out[p] = own ? m_lat[p] : func_out[p];
            e_oe[p]  = own ? m_dir[p] : func_oe[p];
        end
        if (!rst_n) begin
            check(pad_oe == '0, "R1 pad_oe", pad_oe, '0);
            check(pad_out == '0, "R1 pad_out", pad_out, '0);
            check(reg_rvalid == 1'b0, "R1 rvalid", NP'(reg_rvalid), '0);
        end
        check(pad_out === e_out, "R8 pad_out", pad_out, e_out);
        check(pad_oe === e_oe, "R8 pad_oe", pad_oe, e_oe);
        check(reg_rvalid === m_rvalid, "R9 rvalid", NP'(reg_rvalid), NP'(m_rvalid));
        check(reg_rdata === m_rdata, m_rvalid ? m_tag : "R9 hold",
              NP'(reg_rdata), NP'(m_rdata));
    endtask

    task automatic rnd_pins();
        for (int k = 0; k < NREG; k++) begin
            pad_in[k*32 +: 32]   = $urandom;
            func_out[k*32 +: 32] = $urandom;
            func_oe[k*32 +: 32]  = $urandom;
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        reg_wr = 1; reg_addr = AW'(a); reg_wdata = d;
        cyc();
        reg_wr = 0;
    endtask

    task automatic rd(input int a);
        reg_rd = 1; reg_addr = AW'(a);
        cyc();
        reg_rd = 0;
    endtask

    task automatic read_all();
        for (int w = 0; w < 9*NREG + 2; w++) rd(w*4);
        cyc();
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        rnd_pins();
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        read_all();                                     // R3, R10 readback
        // R4 direction, R2 bank addressing.
        wr((1*NREG+0)*4, 32'hF0F0_00FF);
        wr((1*NREG+1)*4, 32'h8000_0001);
        // R5 set, R6 clear.
        wr((2*NREG+0)*4, 32'h0000_00F3);
        wr((2*NREG+1)*4, 32'hFFFF_0000);
        wr((2*NREG+0)*4, 32'h0000_0000);                // zeros: no effect
        wr((3*NREG+0)*4, 32'h0000_0003);
        wr((3*NREG+1)*4, 32'h0F00_0000);
        // R3 and R10: ignored writes.
        wr(0, 32'hFFFF_FFFF);
        wr((4*NREG)*4, 32'hFFFF_FFFF);
        wr((6*NREG+1)*4, 32'hFFFF_FFFF);
        wr((9*NREG)*4, 32'hFFFF_FFFF);
        // R7 function selectors: pin 1 = 3, pin 63 = 3, pin 20 = 1.
        wr((7*NREG+0)*4, 32'h0000_000C);
        wr((7*NREG+3)*4, 32'hC000_0000);
        wr((7*NREG+1)*4, 32'h0000_0100);
        for (int i = 0; i < 20; i++) begin rnd_pins(); cyc(); end  // R8
        read_all();
        // R9 read/write in one cycle: read sees the old value.
        reg_rd = 1; reg_wr = 1; reg_addr = AW'((2*NREG)*4); reg_wdata = 32'hFFFF_FFFF;
        cyc();
        reg_rd = 0; reg_wr = 0;
        cyc();
        // Mixed random traffic.
        for (int i = 0; i < 600; i++) begin
            reg_rd    = $urandom_range(0, 1);
            reg_wr    = $urandom_range(0, 2) == 0;
            reg_addr  = AW'($urandom_range(0, (9*NREG+2)*4 - 1));
            reg_wdata = $urandom;
            if ($urandom_range(0, 3) == 0) rnd_pins();
            cyc();
        end
        reg_rd = 0; reg_wr = 0;
        read_all();
        // R1: reset in mid-run.
        rst_n = 0;
        repeat (2) cyc();
        rst_n = 1;
        cyc();
        read_all();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule